// File: doc/BRIEF.md
# Register-memory instruction execution core

This block is a compact 32-bit execution engine. It has no register file. Code and data live together in a 512-word local memory, and every instruction names both of its operands by memory address. Each 32-bit instruction uses a single layout. That layout holds an operation code, a flag-based execute condition, three independent write enables (carry flag, zero flag, result), an immediate-source select, and 9-bit destination and source fields. The result goes back to the destination word.

The core is used in two phases. While `rst` is high, the surrounding logic fills the memory through the load port and can read any word back through the same port. Once `rst` falls, the core starts at address 0. It runs each instruction in exactly four clock cycles, in this order: instruction fetch, destination read, source read, then execute with writeback. The instruction's condition, opcode and operands have no effect on this timing.

Top module: `rm_core`

## Requirements
- R1: While `rst` is high, `pc_o` reads 0 and both `c_flag` and `z_flag` read 0. With `load_we` high, each rising edge writes `load_data` into the word at `load_addr`. After `rst` falls, the first instruction is fetched from address 0.
- R2: While `rst` is high, `peek_data` shows, one cycle later, the word at the address that `load_addr` held at the previous rising edge. Memory contents survive a reset.
- R3: Instruction layout: bits 31:24 opcode, bits 23:22 condition, bit 21 write C, bit 20 write Z, bit 19 write result, bit 18 immediate select, bits 17:9 destination address, bits 8:0 source address. The result is stored at the destination address. Example: word 10 holds 5 and word 6 holds 3; an address-form ADD of 10 with 6 leaves 8 in word 10.
- R4: If bit 18 is 0, the source operand is the memory word at the source address. If bit 18 is 1, the source operand is the 9-bit source field itself, zero-extended. Example: an immediate ADD of 6 to a word holding 5 leaves 11.
- R5: Opcodes: 0x00 MOV (result = source), 0x01 ADD (dest + source), 0x02 SUB (dest - source), 0x03 AND, 0x04 OR, 0x05 XOR. For ADD, C is the carry out of bit 31. For SUB, C is the borrow (dest < source, unsigned). For the other four, C is 0. Z is 1 exactly when the 32-bit result is 0.
- R6: Each write-control bit acts alone. With bit 19 clear, the destination word is unchanged. With bit 21 or bit 20 clear, C or Z respectively keeps its old value.
- R7: Condition bit 22 set requires C=1, and bit 23 set requires Z=1. With both bits clear, the instruction always executes. An instruction whose condition fails writes no memory word and no flag, advances the PC by one, and still takes four cycles.
- R8: Opcode 0x06 is a jump. When its condition holds, the PC is loaded with the low 9 bits of the source operand, taken from an immediate or from memory per bit 18. A jump writes no memory word and no flag, whatever its write-control bits say.
- R9: For every instruction other than a taken jump, the PC advances by one. It wraps from 511 to 0.
- R10: Every instruction takes exactly four cycles. `retire` is high only in the fourth (execute) cycle. `pc_o`, `c_flag` and `z_flag` change only on the rising edge that ends a cycle in which `retire` is high.
- R11: Opcodes outside 0x00 to 0x06 write no memory word and no flag, and advance the PC by one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also enables the load port |
| load_we | input | 1 | Write strobe for the load port (effective only during reset) |
| load_addr | input | 9 | Load/readback address |
| load_data | input | 32 | Word to write through the load port |
| peek_data | output | 32 | Readback of the word at the previous `load_addr` during reset |
| retire | output | 1 | High in the execute cycle of each instruction |
| pc_o | output | 9 | Program counter |
| c_flag | output | 1 | Carry/borrow flag |
| z_flag | output | 1 | Zero flag |

## Verification
After `rst` falls at a falling edge, the first instruction shows `retire` high just after the third rising edge. Its PC and flag updates appear just after the fourth rising edge, and each later instruction follows four edges after the one before it. The bench therefore samples `retire` 1 ns after edge 3 of each group and the PC and flags 1 ns after edge 4, then compares them with a bench-side model stepped once per instruction. Memory results are read back after the run by raising reset and presenting one address per cycle, and each `peek_data` value is sampled 1 ns after the edge that follows its address.

// File: rtl/rmc_pkg.sv
package rmc_pkg;

    localparam int WORD_W = 32;
    localparam int PC_W   = 9;

    typedef enum logic [7:0] {
        OP_MOV = 8'h00,
        OP_ADD = 8'h01,
        OP_SUB = 8'h02,
        OP_AND = 8'h03,
        OP_OR  = 8'h04,
        OP_XOR = 8'h05,
        OP_JMP = 8'h06
    } op_e;

    typedef struct packed {
        logic [7:0]      op;
        logic [1:0]      cond;   // [0] needs C, [1] needs Z
        logic            wr_c;
        logic            wr_z;
        logic            wr_r;
        logic            imm;
        logic [PC_W-1:0] dst;
        logic [PC_W-1:0] src;
    } instr_t;

    typedef struct packed {
        logic [WORD_W-1:0] val;
        logic              c;
        logic              z;
        logic              wb_ok;    // op may update result/flags
        logic              is_jump;
    } alu_out_t;

    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,
        ST_RDDST = 2'd1,
        ST_RDSRC = 2'd2,
        ST_EXEC  = 2'd3
    } state_e;

    function automatic logic cond_ok(input logic [1:0] cond, input logic c, input logic z);
        return (!cond[0] || c) && (!cond[1] || z);
    endfunction

endpackage

// File: rtl/rmc_mem.sv
module rmc_mem #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] ram [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            ram[addr] <= wdata;
        end
        rdata <= ram[addr];
    end

endmodule

// File: rtl/rmc_alu.sv
module rmc_alu
    import rmc_pkg::*;
(
    input  logic [7:0]        op,
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    output alu_out_t          res
);
    logic [WORD_W:0] sum;
    logic [WORD_W:0] diff;

    always_comb begin
        sum         = {1'b0, a} + {1'b0, b};
        diff        = {1'b0, a} - {1'b0, b};
        res         = '0;
        res.wb_ok   = 1'b1;
        case (op)
            OP_MOV: res.val = b;
            OP_ADD: begin
                res.val = sum[WORD_W-1:0];
                res.c   = sum[WORD_W];
            end
            OP_SUB: begin
                res.val = diff[WORD_W-1:0];
                res.c   = diff[WORD_W];
            end
            OP_AND: res.val = a & b;
            OP_OR:  res.val = a | b;
            OP_XOR: res.val = a ^ b;
            OP_JMP: begin
                res.wb_ok   = 1'b0;
                res.is_jump = 1'b1;
            end
            default: res.wb_ok = 1'b0;
        endcase
        res.z = (res.val == '0);
    end

endmodule

// File: rtl/rmc_seq.sv
module rmc_seq
    import rmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] mem_rdata,
    input  alu_out_t          alu_res,
    output logic [PC_W-1:0]   mem_addr,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_wdata,
    output logic [7:0]        alu_op,
    output logic [WORD_W-1:0] alu_a,
    output logic [WORD_W-1:0] alu_b,
    output logic [PC_W-1:0]   pc,
    output logic              c_flag,
    output logic              z_flag,
    output logic              retire
);
    state_e            state;
    instr_t            ir;
    instr_t            ir_now;
    logic [WORD_W-1:0] dst_q;
    logic [WORD_W-1:0] src_val;
    logic              pass;

    always_comb begin
        ir_now    = instr_t'(mem_rdata);
        src_val   = ir.imm ? {{(WORD_W-PC_W){1'b0}}, ir.src} : mem_rdata;
        pass      = cond_ok(ir.cond, c_flag, z_flag);
        alu_op    = ir.op;
        alu_a     = dst_q;
        alu_b     = src_val;
        mem_addr  = pc;
        mem_we    = 1'b0;
        mem_wdata = alu_res.val;
        retire    = (state == ST_EXEC);
        case (state)
            ST_RDDST: mem_addr = ir_now.dst;
            ST_RDSRC: mem_addr = ir.src;
            ST_EXEC: begin
                mem_addr = ir.dst;
                mem_we   = pass && alu_res.wb_ok && ir.wr_r;
            end
            default: mem_addr = pc;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_FETCH;
            pc     <= '0;
            c_flag <= 1'b0;
            z_flag <= 1'b0;
            ir     <= '0;
            dst_q  <= '0;
        end else begin
            case (state)
                ST_FETCH: state <= ST_RDDST;
                ST_RDDST: begin
                    ir    <= ir_now;
                    state <= ST_RDSRC;
                end
                ST_RDSRC: begin
                    dst_q <= mem_rdata;
                    state <= ST_EXEC;
                end
                ST_EXEC: begin
                    state <= ST_FETCH;
                    if (pass && alu_res.is_jump) begin
                        pc <= src_val[PC_W-1:0];
                    end else begin
                        pc <= pc + PC_W'(1);
                    end
                    if (pass && alu_res.wb_ok) begin
                        if (ir.wr_c) c_flag <= alu_res.c;
                        if (ir.wr_z) z_flag <= alu_res.z;
                    end
                end
                default: state <= ST_FETCH;
            endcase
        end
    end

endmodule

// File: rtl/rm_core.sv
module rm_core
    import rmc_pkg::*;
#(
    parameter int DATA_W = WORD_W,
    parameter int ADDR_W = PC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_we,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [DATA_W-1:0] load_data,
    output logic [DATA_W-1:0] peek_data,
    output logic              retire,
    output logic [ADDR_W-1:0] pc_o,
    output logic              c_flag,
    output logic              z_flag
);
    logic [ADDR_W-1:0] seq_addr;
    logic              seq_we;
    logic [DATA_W-1:0] seq_wdata;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_we;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata;
    logic [7:0]        alu_op;
    logic [DATA_W-1:0] alu_a;
    logic [DATA_W-1:0] alu_b;
    alu_out_t          alu_res;

    always_comb begin
        mem_addr  = rst ? load_addr : seq_addr;
        mem_we    = rst ? load_we   : seq_we;
        mem_wdata = rst ? load_data : seq_wdata;
    end

    assign peek_data = mem_rdata;

    rmc_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

    rmc_alu u_alu (
        .op  (alu_op),
        .a   (alu_a),
        .b   (alu_b),
        .res (alu_res)
    );

    rmc_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .mem_rdata (mem_rdata),
        .alu_res   (alu_res),
        .mem_addr  (seq_addr),
        .mem_we    (seq_we),
        .mem_wdata (seq_wdata),
        .alu_op    (alu_op),
        .alu_a     (alu_a),
        .alu_b     (alu_b),
        .pc        (pc_o),
        .c_flag    (c_flag),
        .z_flag    (z_flag),
        .retire    (retire)
    );

endmodule

// File: rtl/rm_core_chk.sv
module rm_core_chk (
    input logic       clk,
    input logic       rst,
    input logic       retire,
    input logic [8:0] pc_o,
    input logic       c_flag,
    input logic       z_flag
);
    AST_RESET_EXIT_STATE: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pc_o == 9'd0 && !c_flag && !z_flag)); // R1

    AST_PC_HELD_OUTSIDE_EXEC: assert property (@(posedge clk) disable iff (rst)
        !retire |=> $stable(pc_o)); // R10

    AST_FLAGS_HELD_OUTSIDE_EXEC: assert property (@(posedge clk) disable iff (rst)
        !retire |=> ($stable(c_flag) && $stable(z_flag))); // R10

    AST_RETIRE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        retire |=> !retire); // R10

    AST_RETIRE_GAP: assert property (@(posedge clk) disable iff (rst)
        retire |-> (!$past(retire, 1) && !$past(retire, 2) && !$past(retire, 3))); // R10

endmodule

bind rm_core rm_core_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .retire (retire),
    .pc_o   (pc_o),
    .c_flag (c_flag),
    .z_flag (z_flag)
);

// File: tb/sim_rm_core.sv
`timescale 1ns/1ps
module sim_rm_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_we = 1'b0;
    logic [8:0]  load_addr = '0;
    logic [31:0] load_data = '0;
    logic [31:0] peek_data;
    logic        retire;
    logic [8:0]  pc_o;
    logic        c_flag;
    logic        z_flag;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    bit [31:0] img   [512];
    bit [31:0] m_mem [512];
    bit [8:0]  m_pc;
    bit        m_c;
    bit        m_z;

    always #2 clk = ~clk;

    rm_core u0 (
        .clk(clk), .rst(rst), .load_we(load_we), .load_addr(load_addr),
        .load_data(load_data), .peek_data(peek_data), .retire(retire),
        .pc_o(pc_o), .c_flag(c_flag), .z_flag(z_flag)
    );

    function automatic bit [31:0] enc(input bit [7:0] op, input bit [1:0] cond,
                                      input bit [2:0] wr, input bit imm,
                                      input bit [8:0] dst, input bit [8:0] src);
        return {op, cond, wr, imm, dst, src};   // wr = {C, Z, result}
    endfunction

    task automatic check(input string req, input bit [31:0] act, input bit [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // model of one instruction, written from the requirements
    task automatic m_step();
        bit [31:0] w, dv, sv, r;
        bit [32:0] wide;
        bit cc, ok, jmp, pass;
        w   = m_mem[m_pc];
        dv  = m_mem[w[17:9]];
        sv  = w[18] ? {23'd0, w[8:0]} : m_mem[w[8:0]];
        ok  = 1; jmp = 0; cc = 0; r = 0;
        case (w[31:24])
            8'h00: r = sv;
            8'h01: begin wide = {1'b0, dv} + {1'b0, sv}; r = wide[31:0]; cc = wide[32]; end
            8'h02: begin wide = {1'b0, dv} - {1'b0, sv}; r = wide[31:0]; cc = wide[32]; end
            8'h03: r = dv & sv;
            8'h04: r = dv | sv;
            8'h05: r = dv ^ sv;
            8'h06: begin ok = 0; jmp = 1; end
            default: ok = 0;
        endcase
        pass = (!w[22] || m_c) && (!w[23] || m_z);
        if (pass && jmp) m_pc = sv[8:0];
        else             m_pc = m_pc + 9'd1;
        if (pass && ok) begin
            if (w[19]) m_mem[w[17:9]] = r;
            if (w[21]) m_c = cc;
            if (w[20]) m_z = (r == 32'd0);
        end
    endtask

    task automatic load_image();
        @(negedge clk);
        rst = 1'b1;
        for (int a = 0; a < 512; a++) begin
            load_we = 1'b1; load_addr = 9'(a); load_data = img[a];
            m_mem[a] = img[a];
            @(negedge clk);
        end
        load_we = 1'b0;
        m_pc = 0; m_c = 0; m_z = 0;
        @(posedge clk); #1;
        check("R1 reset pc", 32'(pc_o), 32'd0);
        check("R1 reset flags", {30'd0, c_flag, z_flag}, 32'd0);
    endtask

    task automatic run(input int n);
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < n; k++) begin
            repeat (3) @(posedge clk);
            #1;
            check("R10 retire in 4th cycle", 32'(retire), 32'd1);
            @(posedge clk);
            #1;
            m_step();
            check("R9 pc", 32'(pc_o), 32'(m_pc));
            check("R5 R7 flags", {30'd0, c_flag, z_flag}, {30'd0, m_c, m_z});
            check("R10 retire low after exec", 32'(retire), 32'd0);
        end
        @(negedge clk);
        rst = 1'b1;
    endtask

    task automatic peek(input int a, output bit [31:0] v);
        @(negedge clk);
        load_addr = 9'(a);
        @(posedge clk);
        #1;
        v = peek_data;
    endtask

    task automatic compare_all(input string req);
        bit [31:0] v;
        @(posedge clk); #1;
        check("R1 flags cleared by reset", {23'd0, pc_o, c_flag, z_flag}, 32'd0);
        for (int a = 0; a < 512; a++) begin
            peek(a, v);
            check(req, v, m_mem[a]);
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        bit [31:0] v;
        int n;
        repeat (3) @(posedge clk);

        // Directed program: address/immediate form, flag-only write, jumps, wrap, undefined op
        for (int a = 0; a < 512; a++) img[a] = 32'hA5A5_0000 + 32'(a);
        img[10] = 5; img[6] = 3; img[11] = 5; img[12] = 77; img[13] = 32'h1234; img[15] = 32'h55;
        img[30] = 32'hFFFF_FFFF;                              // register jump target -> 511
        img[0]   = enc(8'h01, 2'b00, 3'b001, 0, 9'd10, 9'd6);  // R3 ADD 10,6
        img[1]   = enc(8'h01, 2'b00, 3'b001, 1, 9'd11, 9'd6);  // R4 ADD 11,#6
        img[2]   = enc(8'h02, 2'b00, 3'b110, 0, 9'd12, 9'd12); // R6 flags only
        img[3]   = enc(8'h06, 2'b10, 3'b111, 1, 9'd0, 9'd20);  // R8 jump on Z
        img[4]   = enc(8'h00, 2'b00, 3'b001, 1, 9'd13, 9'd1);  // must be skipped
        img[20]  = enc(8'h06, 2'b01, 3'b000, 1, 9'd0, 9'd4);   // R7 fails (C=0)
        img[21]  = enc(8'h06, 2'b00, 3'b000, 0, 9'd0, 9'd30);  // jump via memory
        img[511] = enc(8'hC3, 2'b00, 3'b111, 1, 9'd15, 9'd0);  // R11 undefined op
        load_image();
        peek(10, v); check("R2 peek loaded word", v, 32'd5);
        run(7);
        check("R9 wrap 511 to 0", 32'(pc_o), 32'd0);
        compare_all("R6 memory after directed run");
        peek(10, v); check("R3 address-form add", v, 32'd8);
        peek(11, v); check("R4 immediate add", v, 32'd11);
        peek(12, v); check("R6 result write disabled", v, 32'd77);
        peek(13, v); check("R8 skipped by taken jump", v, 32'h1234);
        peek(15, v); check("R11 undefined op no write", v, 32'h55);

        // Sweep: every op x write-enable x source form, varied conditions
        n = 200;
        for (int k = 0; k < 256; k++) begin
            case (k % 8)
                0: img[256 + k] = 32'd0;
                1: img[256 + k] = 32'hFFFF_FFFF;
                2: img[256 + k] = 32'h8000_0000;
                default: img[256 + k] = (32'(k) * 32'h9E37_79B9) ^ (32'(k) << 20);
            endcase
        end
        for (int i = 0; i < 256; i++) begin
            bit [7:0] op;
            bit [8:0] s;
            op = (i % 23 == 22) ? 8'h9A : 8'(i % 6);
            s  = ((i / 48) % 2 == 1) ? 9'((i * 37 + 1) % 512) : 9'(256 + (i * 11 + 3) % 256);
            if (i < n)
                img[i] = enc(op, 2'((i / 3) % 4), 3'((i / 6) % 8), bit'((i / 48) % 2),
                             9'(256 + (i * 7) % 64), s);
            else
                img[i] = enc(8'h06, 2'b00, 3'b000, 1, 9'd0, 9'(n));  // park loop
        end
        load_image();
        run(n + 3);
        compare_all("R5 R6 R7 memory after sweep");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule